// File: doc/BRIEF.md
# Three-Step Motion Vector Search Engine

This block finds the motion vector of one square macroblock inside a reference window. It reads the current block and the reference window through two synchronous read ports. For each candidate displacement it adds up the absolute pixel differences (SAD), one pixel pair per clock. The search is coarse to fine. A round checks nine points, the centre and its eight neighbours at the current step size. The centre then moves to the best point and the step halves, until a round at step 1 has been done.

A mode input selects a variant that favours the centre. In that variant the first round also checks the eight points one pixel around the origin. The search can then stop early: with a zero vector when the origin wins, or after checking the missing neighbours of a winning one-pixel point. If the best point lies further out, the search carries on as the plain search. A start pulse launches a search. When the search completes, the block reports the signed vector, its SAD and the number of candidates evaluated, and holds them with `done` high.

Top module: `tss_search_engine`

## Requirements
- R1: After reset, `done` is 0 and `mv_x`, `mv_y`, `min_sad` and `cand_count` are all 0.
- R2: With `ntss_mode`=0, the first round is centred on (0,0) with step (RANGE+1)/2, which is 4 for the default range. Each later round is centred on the best point so far, with the step halved. The last round uses step 1. The shared centre is never evaluated again, so a ±7 search evaluates 25 candidates. Any candidate outside ±RANGE is skipped.
- R3: `min_sad` equals the exact sum of |cur - ref| over all BLK×BLK pixel pairs at the reported displacement, and no evaluated candidate has a smaller sum.
- R4: A candidate replaces the best only when its SAD is strictly smaller. The centre is evaluated first. Ring points are then evaluated in this order: the row dy=-s from left to right, then (−s,0), then (+s,0), then the row dy=+s from left to right.
- R5: With `ntss_mode`=1, the first round evaluates the centre, the eight step points and then the eight distance-1 points, in the order of R4. If (0,0) is still best, the search ends with a zero vector and a count of 17.
- R6: With `ntss_mode`=1, if the best point after the first round is a distance-1 neighbour, only its not-yet-evaluated neighbours are checked, and then the search ends. That is 5 points for a corner neighbour (count 22) and 3 for an edge neighbour (count 20).
- R7: With `ntss_mode`=1, if the best point after the first round is a step point, rounds at step 2 and step 1 follow around it, for a count of 33.
- R8: `done` stays high, with all results stable, until the next `start`. A `start` makes `done` low from the next cycle on.
- R9: The current block address is row*BLK+col. The reference address is (row+dy+RANGE)*(BLK+2*RANGE)+(col+dx+RANGE). Read data is expected one cycle after its address. Positive dx means rightward and positive dy means downward.
- R10: `mv_x` and `mv_y` are two's-complement values of $clog2(RANGE+1)+1 bits, and each lies within ±RANGE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a search (accepted when idle or done) |
| ntss_mode | input | 1 | 1 selects the centre-biased early-stop variant |
| cur_addr | output | CAW | Current block read address |
| cur_data | input | PIX_W | Current block pixel, one cycle after address |
| ref_addr | output | RAW | Reference window read address |
| ref_data | input | PIX_W | Reference pixel, one cycle after address |
| mv_x | output | VW | Horizontal displacement, signed |
| mv_y | output | VW | Vertical displacement, signed |
| min_sad | output | SAD_W | SAD at the reported displacement |
| cand_count | output | CNT_W | Candidates evaluated in the last search |
| done | output | 1 | Search complete, results valid |

## Verification
The bench builds the block with BLK=4 and the default RANGE=7. Each candidate then costs only 16 pixel pairs, while the full ±7 window keeps the 25, 17, 20, 22 and 33 candidate counts that the plain and centre-biased orderings produce. A small block lets the bench recompute every candidate SAD from its own image arrays. It can therefore use ramp, random and column-symmetric images to force unique minima, corner and edge early stops and deliberate SAD ties.

// File: rtl/tss_pkg.sv
package tss_pkg;
  typedef enum logic [1:0] {PH_CTR, PH_RING, PH_NEAR, PH_EXTRA} phase_t;
  typedef enum logic [1:0] {ST_IDLE, ST_SEL, ST_RUN, ST_DONE} state_t;
endpackage

// File: rtl/tss_cand_gen.sv
module tss_cand_gen
  import tss_pkg::*;
#(
  parameter int RANGE = 7,
  parameter int VW    = 4
) (
  input  phase_t                phase,
  input  logic [2:0]            k,
  input  logic [VW-1:0]         step,
  input  logic signed [VW-1:0]  base_x,
  input  logic signed [VW-1:0]  base_y,
  output logic signed [VW-1:0]  cand_x,
  output logic signed [VW-1:0]  cand_y,
  output logic                  cand_ok
);
  localparam int WW = VW + 2;
  localparam logic signed [WW-1:0] LIM = WW'(RANGE);

  logic signed [WW-1:0] s, dx, dy, wx, wy;
  logic in_win, in_core;

  always_comb begin
    s = $signed(WW'(step));
    // ring ordering: top row L->R, middle L then R, bottom row L->R
    case (k)
      3'd0, 3'd3, 3'd5: dx = -s;
      3'd1, 3'd6:       dx = '0;
      default:          dx = s;
    endcase
    if (k < 3'd3)      dy = -s;
    else if (k < 3'd5) dy = '0;
    else               dy = s;
    if (phase == PH_CTR) begin
      dx = '0;
      dy = '0;
    end
    wx = WW'(base_x) + dx;
    wy = WW'(base_y) + dy;
    in_win  = (wx >= -LIM) && (wx <= LIM) && (wy >= -LIM) && (wy <= LIM);
    in_core = (wx >= -1) && (wx <= 1) && (wy >= -1) && (wy <= 1);
    cand_ok = in_win && !((phase == PH_EXTRA) && in_core);
    cand_x  = wx[VW-1:0];
    cand_y  = wy[VW-1:0];
  end
endmodule

// File: rtl/tss_sad_acc.sv
module tss_sad_acc #(
  parameter int BLK   = 16,
  parameter int PIX_W = 8,
  parameter int RANGE = 7,
  parameter int VW    = 4,
  parameter int CAW   = 8,
  parameter int RAW   = 10,
  parameter int SAD_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic signed [VW-1:0] cand_x,
  input  logic signed [VW-1:0] cand_y,
  output logic [CAW-1:0]       cur_addr,
  output logic [RAW-1:0]       ref_addr,
  input  logic [PIX_W-1:0]     cur_data,
  input  logic [PIX_W-1:0]     ref_data,
  output logic [SAD_W-1:0]     sad,
  output logic                 sad_vld
);
  localparam int RW  = (BLK > 1) ? $clog2(BLK) : 1;
  localparam int WIN = BLK + 2*RANGE;

  logic busy_q, busy_d, rd_q, rd_d, last_q, last_d, fin_q;
  logic [RW-1:0] row_q, row_d, col_q, col_d;
  logic signed [VW-1:0] cx_q, cx_d, cy_q, cy_d;
  logic [SAD_W-1:0] acc_q, acc_d;
  logic [PIX_W-1:0] diff;
  logic [RAW+1:0] rrow, rcol;
  logic row_end, col_end;

  assign row_end  = (row_q == RW'(BLK-1));
  assign col_end  = (col_q == RW'(BLK-1));
  assign rrow     = (RAW+2)'(row_q) + (RAW+2)'(cy_q) + (RAW+2)'(RANGE);
  assign rcol     = (RAW+2)'(col_q) + (RAW+2)'(cx_q) + (RAW+2)'(RANGE);
  assign ref_addr = RAW'(rrow * (RAW+2)'(WIN) + rcol);
  assign cur_addr = CAW'(row_q) * CAW'(BLK) + CAW'(col_q);
  assign diff     = (cur_data > ref_data) ? cur_data - ref_data : ref_data - cur_data;
  assign sad      = acc_q;
  assign sad_vld  = fin_q;

  always_comb begin
    busy_d = busy_q;
    row_d  = row_q;
    col_d  = col_q;
    cx_d   = cx_q;
    cy_d   = cy_q;
    rd_d   = busy_q;
    last_d = busy_q && row_end && col_end;
    acc_d  = rd_q ? acc_q + SAD_W'(diff) : acc_q;
    if (go) begin
      busy_d = 1'b1;
      row_d  = '0;
      col_d  = '0;
      cx_d   = cand_x;
      cy_d   = cand_y;
      acc_d  = '0;
    end else if (busy_q) begin
      if (col_end) begin
        col_d = '0;
        if (row_end) busy_d = 1'b0;
        else         row_d  = row_q + 1'b1;
      end else begin
        col_d = col_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      last_q <= 1'b0;
      fin_q  <= 1'b0;
      row_q  <= '0;
      col_q  <= '0;
      cx_q   <= '0;
      cy_q   <= '0;
      acc_q  <= '0;
    end else begin
      busy_q <= busy_d;
      rd_q   <= rd_d;
      last_q <= last_d;
      fin_q  <= last_q;
      row_q  <= row_d;
      col_q  <= col_d;
      cx_q   <= cx_d;
      cy_q   <= cy_d;
      acc_q  <= acc_d;
    end
  end

  // a new candidate only starts once the previous pixel stream has drained
  p_go_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (!busy_q && !rd_q && !last_q));
  p_vld_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sad_vld |=> !sad_vld);
  p_addr_in_win_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (int'(ref_addr) < WIN*WIN));
endmodule

// File: rtl/tss_search_engine.sv
module tss_search_engine
  import tss_pkg::*;
#(
  parameter  int BLK   = 16,
  parameter  int PIX_W = 8,
  parameter  int RANGE = 7,
  localparam int VW    = $clog2(RANGE+1) + 1,
  localparam int CAW   = $clog2(BLK*BLK),
  localparam int RAW   = $clog2((BLK+2*RANGE)*(BLK+2*RANGE)),
  localparam int SAD_W = $clog2(BLK*BLK*((1 << PIX_W) - 1) + 1),
  localparam int CNT_W = $clog2(18 + 8*VW)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 ntss_mode,
  output logic [CAW-1:0]       cur_addr,
  input  logic [PIX_W-1:0]     cur_data,
  output logic [RAW-1:0]       ref_addr,
  input  logic [PIX_W-1:0]     ref_data,
  output logic signed [VW-1:0] mv_x,
  output logic signed [VW-1:0] mv_y,
  output logic [SAD_W-1:0]     min_sad,
  output logic [CNT_W-1:0]     cand_count,
  output logic                 done
);
  localparam int S0     = (RANGE + 1) / 2;
  localparam int NSTEP  = $clog2(S0 + 1);
  localparam int TSS_PT = 1 + 8*NSTEP;

  logic [1:0] rst_sync;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  state_t state_q, state_d;
  phase_t phase_q, phase_d;
  logic [2:0] k_q, k_d;
  logic [VW-1:0] step_q, step_d;
  logic signed [VW-1:0] base_x_q, base_x_d, base_y_q, base_y_d;
  logic signed [VW-1:0] best_x_q, best_x_d, best_y_q, best_y_d;
  logic [SAD_W-1:0] best_sad_q, best_sad_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic mode_q, mode_d, have_q, have_d;
  logic go, adv;
  logic signed [VW-1:0] cand_x, cand_y;
  logic cand_ok, sad_vld;
  logic [SAD_W-1:0] sad;

  tss_cand_gen #(.RANGE(RANGE), .VW(VW)) u_cand (
    .phase(phase_q), .k(k_q), .step(step_q), .base_x(base_x_q), .base_y(base_y_q),
    .cand_x(cand_x), .cand_y(cand_y), .cand_ok(cand_ok));

  tss_sad_acc #(.BLK(BLK), .PIX_W(PIX_W), .RANGE(RANGE), .VW(VW), .CAW(CAW),
                .RAW(RAW), .SAD_W(SAD_W)) u_sad (
    .clk(clk), .rst_n(rst_n_s), .go(go), .cand_x(cand_x), .cand_y(cand_y),
    .cur_addr(cur_addr), .ref_addr(ref_addr), .cur_data(cur_data), .ref_data(ref_data),
    .sad(sad), .sad_vld(sad_vld));

  always_comb begin
    state_d = state_q;   phase_d = phase_q;   k_d = k_q;   step_d = step_q;
    base_x_d = base_x_q; base_y_d = base_y_q; best_x_d = best_x_q; best_y_d = best_y_q;
    best_sad_d = best_sad_q; cnt_d = cnt_q;   mode_d = mode_q; have_d = have_q;
    go = 1'b0;
    adv = 1'b0;
    case (state_q)
      ST_IDLE, ST_DONE: if (start) begin
        state_d = ST_SEL;  phase_d = PH_CTR; k_d = '0; step_d = VW'(S0);
        base_x_d = '0;     base_y_d = '0;    cnt_d = '0;
        mode_d = ntss_mode; have_d = 1'b0;
      end
      ST_SEL: begin
        if (cand_ok) begin
          go = 1'b1;
          state_d = ST_RUN;
        end else begin
          adv = 1'b1;
        end
      end
      default: if (sad_vld) begin
        cnt_d = cnt_q + 1'b1;
        if (!have_q || (sad < best_sad_q)) begin
          best_x_d = cand_x; best_y_d = cand_y; best_sad_d = sad;
        end
        have_d = 1'b1;
        adv = 1'b1;
      end
    endcase
    if (adv) begin
      state_d = ST_SEL;
      if (phase_q == PH_CTR) begin
        phase_d = PH_RING;
        k_d = '0;
      end else if (k_q != 3'd7) begin
        k_d = k_q + 1'b1;
      end else begin
        k_d = '0;
        case (phase_q)
          PH_RING: begin
            if (mode_q && (step_q == VW'(S0))) begin
              phase_d = PH_NEAR; step_d = VW'(1); base_x_d = '0; base_y_d = '0;
            end else if (step_q == VW'(1)) begin
              state_d = ST_DONE;
            end else begin
              step_d = step_q >> 1; base_x_d = best_x_d; base_y_d = best_y_d;
            end
          end
          PH_NEAR: begin
            if ((best_x_d == '0) && (best_y_d == '0)) begin
              state_d = ST_DONE;
            end else if ((best_x_d >= -1) && (best_x_d <= 1) &&
                         (best_y_d >= -1) && (best_y_d <= 1)) begin
              phase_d = PH_EXTRA; base_x_d = best_x_d; base_y_d = best_y_d;
            end else begin
              phase_d = PH_RING; step_d = VW'(S0 / 2);
              base_x_d = best_x_d; base_y_d = best_y_d;
            end
          end
          default: state_d = ST_DONE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;  phase_q <= PH_CTR; k_q <= '0;      step_q <= '0;
      base_x_q <= '0;      base_y_q <= '0;    best_x_q <= '0; best_y_q <= '0;
      best_sad_q <= '0;    cnt_q <= '0;       mode_q <= 1'b0; have_q <= 1'b0;
    end else begin
      state_q <= state_d;  phase_q <= phase_d; k_q <= k_d;     step_q <= step_d;
      base_x_q <= base_x_d; base_y_q <= base_y_d; best_x_q <= best_x_d; best_y_q <= best_y_d;
      best_sad_q <= best_sad_d; cnt_q <= cnt_d; mode_q <= mode_d; have_q <= have_d;
    end
  end

  assign mv_x       = best_x_q;
  assign mv_y       = best_y_q;
  assign min_sad    = best_sad_q;
  assign cand_count = cnt_q;
  assign done       = (state_q == ST_DONE);

  p_mv_range_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |-> (mv_x >= -RANGE) && (mv_x <= RANGE) && (mv_y >= -RANGE) && (mv_y <= RANGE));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done && !start) |=> done && $stable(mv_x) && $stable(mv_y) && $stable(min_sad)
                         && $stable(cand_count));
  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done && start) |=> !done);
  p_tss_count_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($rose(done) && !mode_q) |-> (int'(cand_count) == TSS_PT));
  p_ntss_centre_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($rose(done) && mode_q && (mv_x == '0) && (mv_y == '0)) |-> (int'(cand_count) == 17));
  p_sad_mono_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (have_q && $past(have_q)) |-> (best_sad_q <= $past(best_sad_q)));
endmodule

// File: tb/sim_tss_search_engine.sv
module sim_tss_search_engine;
  localparam int BLK = 4, PIX_W = 8, RANGE = 7;
  localparam int VW = $clog2(RANGE+1) + 1;
  localparam int CAW = $clog2(BLK*BLK);
  localparam int WIN = BLK + 2*RANGE;
  localparam int RAW = $clog2(WIN*WIN);
  localparam int SAD_W = $clog2(BLK*BLK*255 + 1);
  localparam int CNT_W = $clog2(18 + 8*VW);
  localparam int S0 = (RANGE + 1) / 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ntss_mode = 1'b0;
  logic [CAW-1:0] cur_addr;
  logic [RAW-1:0] ref_addr;
  logic [PIX_W-1:0] cur_data, ref_data;
  logic signed [VW-1:0] mv_x, mv_y;
  logic [SAD_W-1:0] min_sad;
  logic [CNT_W-1:0] cand_count;
  logic done;

  logic [7:0] cur_mem [BLK*BLK];
  logic [7:0] ref_mem [WIN*WIN];
  int n_chk = 0, n_bad = 0;
  int m_bx, m_by, m_bs, m_cnt;
  int lcg;

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cur_data <= cur_mem[cur_addr];
    ref_data <= ref_mem[ref_addr];
  end

  tss_search_engine #(.BLK(BLK), .PIX_W(PIX_W), .RANGE(RANGE)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .ntss_mode(ntss_mode),
    .cur_addr(cur_addr), .cur_data(cur_data), .ref_addr(ref_addr), .ref_data(ref_data),
    .mv_x(mv_x), .mv_y(mv_y), .min_sad(min_sad), .cand_count(cand_count), .done(done));

  task automatic check(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int sad_at(int dx, int dy);
    int s = 0;
    for (int r = 0; r < BLK; r++)
      for (int c = 0; c < BLK; c++)
        s += iabs(int'(cur_mem[r*BLK+c]) - int'(ref_mem[(r+dy+RANGE)*WIN + c+dx+RANGE]));
    return s;
  endfunction

  task automatic ring(int bx, int by, int s, bit extra);
    for (int k = 0; k < 8; k++) begin
      int ox, oy, px, py, v;
      oy = (k < 3) ? -s : ((k < 5) ? 0 : s);
      ox = (k == 0 || k == 3 || k == 5) ? -s : ((k == 1 || k == 6) ? 0 : s);
      px = bx + ox;
      py = by + oy;
      if (iabs(px) > RANGE || iabs(py) > RANGE) continue;
      if (extra && iabs(px) <= 1 && iabs(py) <= 1) continue;
      v = sad_at(px, py);
      m_cnt++;
      if (v < m_bs) begin m_bs = v; m_bx = px; m_by = py; end
    end
  endtask

  task automatic model(bit m);
    m_bx = 0; m_by = 0; m_bs = sad_at(0, 0); m_cnt = 1;
    if (!m) begin
      for (int s = S0; s >= 1; s = s / 2) ring(m_bx, m_by, s, 1'b0);
    end else begin
      ring(0, 0, S0, 1'b0);
      ring(0, 0, 1, 1'b0);
      if (m_bx == 0 && m_by == 0) begin
      end else if (iabs(m_bx) <= 1 && iabs(m_by) <= 1) begin
        ring(m_bx, m_by, 1, 1'b1);
      end else begin
        for (int s = S0 / 2; s >= 1; s = s / 2) ring(m_bx, m_by, s, 1'b0);
      end
    end
  endtask

  task automatic fill_ramp();
    for (int y = 0; y < WIN; y++)
      for (int x = 0; x < WIN; x++) ref_mem[y*WIN+x] = 8'(4*x + 9*y);
  endtask

  task automatic fill_uniform(int v);
    for (int i = 0; i < WIN*WIN; i++) ref_mem[i] = 8'(v);
    for (int i = 0; i < BLK*BLK; i++) cur_mem[i] = 8'(v);
  endtask

  task automatic fill_rand(int seed);
    lcg = seed;
    for (int i = 0; i < WIN*WIN; i++) begin
      lcg = lcg * 1103515245 + 12345;
      ref_mem[i] = lcg[23:16];
    end
  endtask

  task automatic cur_from_ref(int sx, int sy);
    for (int r = 0; r < BLK; r++)
      for (int c = 0; c < BLK; c++)
        cur_mem[r*BLK+c] = ref_mem[(r+sy+RANGE)*WIN + c+sx+RANGE];
  endtask

  task automatic run(bit m);
    int guard = 0;
    @(negedge clk); start = 1'b1; ntss_mode = m;
    @(negedge clk); start = 1'b0;
    check("R8 done low after start", int'(done), 0);
    while (!done && guard < 20000) begin @(negedge clk); guard++; end
    if (!done) check("R8 search completes", 0, 1);
  endtask

  task automatic run_vs_model(string rq, bit m);
    run(m);
    model(m);
    check({rq, " R10 mv_x"}, int'(mv_x), m_bx);
    check({rq, " R10 mv_y"}, int'(mv_y), m_by);
    check({rq, " R3 min_sad"}, int'(min_sad), m_bs);
    check({rq, " count"}, int'(cand_count), m_cnt);
  endtask

  task automatic t_reset();
    check("R1 done", int'(done), 0);
    check("R1 mv_x", int'(mv_x), 0);
    check("R1 mv_y", int'(mv_y), 0);
    check("R1 min_sad", int'(min_sad), 0);
    check("R1 cand_count", int'(cand_count), 0);
  endtask

  task automatic t_uniform_tss();
    fill_uniform(80);
    run_vs_model("R4 uniform", 1'b0);
    check("R4 centre kept x", int'(mv_x), 0);
    check("R2 count 25", int'(cand_count), 25);
  endtask

  task automatic t_ramp_tss();
    fill_ramp(); cur_from_ref(3, -5);
    run_vs_model("R2 ramp", 1'b0);
    check("R2 count 25", int'(cand_count), 25);
  endtask

  task automatic t_rand_tss();
    fill_rand(17); cur_from_ref(-2, 6);
    run_vs_model("R9 rand a", 1'b0);
    fill_rand(901); cur_from_ref(5, 1);
    run_vs_model("R9 rand b", 1'b1);
  endtask

  task automatic t_tie_order();
    for (int y = 0; y < WIN; y++)
      for (int x = 0; x < WIN; x++) ref_mem[y*WIN+x] = 8'(6*iabs(2*x - (WIN-1)));
    for (int i = 0; i < BLK*BLK; i++) cur_mem[i] = 8'd200;
    run_vs_model("R4 ties", 1'b0);
    check("R4 earliest tie x", int'(mv_x), -7);
    check("R4 earliest tie y", int'(mv_y), -7);
  endtask

  task automatic t_ntss_centre();
    fill_uniform(33);
    run_vs_model("R5 centre", 1'b1);
    check("R5 count 17", int'(cand_count), 17);
  endtask

  task automatic t_ntss_near();
    fill_ramp(); cur_from_ref(1, 1);
    run_vs_model("R6 corner", 1'b1);
    check("R6 corner count 22", int'(cand_count), 22);
    check("R6 corner mv_x", int'(mv_x), 1);
    fill_ramp(); cur_from_ref(1, 0);
    run_vs_model("R6 edge", 1'b1);
    check("R6 edge count 20", int'(cand_count), 20);
  endtask

  task automatic t_ntss_far();
    fill_ramp(); cur_from_ref(-4, 4);
    run_vs_model("R7 far", 1'b1);
    check("R7 count 33", int'(cand_count), 33);
    check("R7 mv_x", int'(mv_x), -4);
    check("R7 sad zero", int'(min_sad), 0);
  endtask

  task automatic t_hold();
    int sx, sy, ss, sc;
    sx = int'(mv_x); sy = int'(mv_y); ss = int'(min_sad); sc = int'(cand_count);
    repeat (12) @(negedge clk);
    check("R8 done held", int'(done), 1);
    check("R8 mv_x held", int'(mv_x), sx);
    check("R8 sad held", int'(min_sad), ss);
    check("R8 count held", int'(cand_count), sc);
    check("R8 mv_y held", int'(mv_y), sy);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog all-R actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    fill_uniform(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_uniform_tss();
    t_ramp_tss();
    t_rand_tss();
    t_tie_order();
    t_ntss_centre();
    t_ntss_near();
    t_ntss_far();
    t_hold();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule